// File: doc/BRIEF.md
# Byte-Wide Non-Volatile Memory Access Sequencer

This block sits between a simple request port and a byte-wide multi-time-programmable memory macro. It drives every control pin of the macro with the ordering and delays the macro needs.

- **Requests.** Read, program and erase requests arrive with an address and a data byte. Each one is turned into a pin sequence:
  - The chip enable settles first.
  - The write strobe is nested inside the program or erase enable.
  - A chip-enable-high pulse follows every operation, which clears the macro's internal write register.
- **Power and idle.** The block holds the macro in reset and idle while the supply is not good. It waits out the start-up delay before it accepts work. It can also park the macro in its low-power idle state and wake it again.

Every delay is written as a time in nanoseconds. The block turns it into a cycle count from the clock frequency, rounding up. A program request can ask for a read-modify-write. In that case the byte is read first. An erase is inserted only when some requested bit must go from 0 to 1. The program then follows.

The block does not queue requests. A request that arrives while an operation, the start-up wait or the idle period is in progress is refused with a one-cycle error pulse. A request with an unknown operation code is refused the same way.

Top module: `nvm_seq`

## Requirements
- R1: While `supply_ok` is low, `m_rst_n` and `m_idle_n` are low and `req_ready` is low. After `supply_ok` rises, `req_ready` stays low for at least the start-up count of cycles.
- R2: For a program (`req_op` = 2'b01), `m_pgm_n` falls at least the enable-setup count of cycles before `m_we_n` falls. `m_we_n` then stays low for at least the pulse count. `m_pgm_n` stays low for at least the write-hold count after `m_we_n` rises. While `m_we_n` is low, exactly one of `m_pgm_n`/`m_ers_n` is low.
- R3: An erase (`req_op` = 2'b10) follows the same ordering and counts as R2, using `m_ers_n`, and leaves the byte at all ones.
- R4: `m_ce_n` has been low for at least the chip-enable setup count before `m_we_n` falls and before `m_clk` rises.
- R5: `m_addr` and `m_din` do not change while `m_ce_n` is low.
- R6: Before every fall of `m_ce_n`, `m_ce_n` has been high for at least the chip-enable-high count.
- R7: A read (`req_op` = 2'b00) raises `m_clk` for at least the sense count and samples `m_dout` after it falls. A completion shows one-cycle `rsp_valid` with `rsp_rdata` equal to the byte read. `rsp_rdata` is 0 for a plain program or erase.
- R8: A plain program only clears bits: the stored byte becomes the old byte AND the new data.
- R9: A program with `req_rmw` high reads the byte first and returns it in `rsp_rdata`. It erases only if (~old & new) is nonzero. It leaves the byte equal to the new data.
- R10: A request while an operation is in progress gives `req_err` high in the same cycle and has no effect on the macro.
- R11: A request during start-up or idle, or with `req_op` = 2'b11, gives `req_err` high in the same cycle and is not executed.
- R12: `sleep_req` in the ready state drives `m_idle_n` low, with `m_ce_n` high, for at least the idle-minimum count. After `m_idle_n` rises, `req_ready` stays low for at least the wake count.
- R13: `m_mode` is always 5'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| supply_ok | input | 1 | High once the supply is good |
| sleep_req | input | 1 | Request to hold the macro in idle |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | A request this cycle would be executed |
| req_op | input | 2 | 00 read, 01 program, 10 erase, 11 invalid |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Program data |
| req_rmw | input | 1 | Program with read-before-write and erase if needed |
| req_err | output | 1 | Request refused this cycle |
| rsp_valid | output | 1 | Operation finished (one cycle) |
| rsp_rdata | output | DATA_W | Byte read by the operation |
| m_rst_n | output | 1 | Macro reset, active low |
| m_idle_n | output | 1 | Macro idle enable, active low |
| m_ce_n | output | 1 | Macro chip enable, active low |
| m_we_n | output | 1 | Macro write strobe, active low |
| m_pgm_n | output | 1 | Macro program enable, active low |
| m_ers_n | output | 1 | Macro erase enable, active low |
| m_clk | output | 1 | Macro read sense clock |
| m_mode | output | 5 | Macro mode select, fixed at user mode |
| m_addr | output | ADDR_W | Macro address |
| m_din | output | DATA_W | Macro write data |
| m_dout | input | DATA_W | Macro read data |

## Verification
The bench models the macro and measures every pin window in cycles, so each timing case is caught at the pin.

- A strobe that opens too early, closes too soon or drops its enable early shows up as a short measured window.
- A missing chip-enable-high gap between back-to-back operations shows up the same way.
- The read-modify-write cases cover a byte that needs only bits cleared and a byte that needs bits set. A design that always erases, never erases, or returns the wrong old byte gives a wrong pulse count or wrong read-back.
- Requests are fired during a write, during start-up, during idle and with the invalid code. A design that queues or executes them changes the stored bytes or the number of write pulses.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF, ST_BOOT, ST_READY, ST_SLEEP, ST_WAKE, ST_CES,
    ST_RATD, ST_RATO, ST_WSET, ST_WPULSE, ST_WHOLD, ST_CEH
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_BAD   = 2'b11
  } nvm_op_e;

  // Time in ns to clock cycles, rounded up, never below one cycle.
  function automatic int unsigned ns_to_cyc(input longint unsigned t_ns,
                                            input longint unsigned clk_hz);
    longint unsigned c;
    c = (t_ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return c[31:0];
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvm_delay_timer.sv
module nvm_delay_timer #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/nvm_seq_fsm.sv
module nvm_seq_fsm
  import nvm_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned C_RSTL  = 1,
  parameter int unsigned C_BOOT  = 1,
  parameter int unsigned C_IDLE  = 1,
  parameter int unsigned C_WAKE  = 1,
  parameter int unsigned C_CES   = 1,
  parameter int unsigned C_ATD   = 1,
  parameter int unsigned C_ATO   = 1,
  parameter int unsigned C_VS    = 1,
  parameter int unsigned C_PULSE = 1,
  parameter int unsigned C_WH    = 1,
  parameter int unsigned C_CEHW  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              sleep_req,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_rmw,
  input  logic              tmr_done,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              m_rst_n,
  output logic              m_idle_n,
  output logic              m_ce_n,
  output logic              m_we_n,
  output logic              m_pgm_n,
  output logic              m_ers_n,
  output logic              m_clk,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_din,
  input  logic [DATA_W-1:0] m_dout
);

  seq_state_e        state_q, state_d;
  nvm_op_e           act_q, act_d;
  logic              rmw_q, rmw_d, pend_q, pend_d, fin_q, fin_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d, rdata_q, rdata_d;
  logic              accept, wr_phase, need_erase;

  function automatic logic [CNT_W-1:0] dur(input int unsigned c);
    return CNT_W'(c - 1);
  endfunction

  assign req_ready  = (state_q == ST_READY) && !sleep_req;
  assign accept     = req_ready && req_valid && (req_op != OP_BAD);
  assign need_erase = |(~rdata_q & data_q);

  always_comb begin
    state_d  = state_q;
    act_d    = act_q;
    rmw_d    = rmw_q;
    pend_d   = pend_q;
    addr_d   = addr_q;
    data_d   = data_q;
    rdata_d  = rdata_q;
    fin_d    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (!supply_ok) begin
      state_d = ST_OFF;
      if (state_q != ST_OFF) begin tmr_load = 1'b1; tmr_val = dur(C_RSTL); end
    end else begin
      unique case (state_q)
        ST_OFF: if (tmr_done) begin
          state_d = ST_BOOT; tmr_load = 1'b1; tmr_val = dur(C_BOOT);
        end
        ST_BOOT, ST_WAKE: if (tmr_done) state_d = ST_READY;
        ST_READY: begin
          if (sleep_req) begin
            state_d = ST_SLEEP; tmr_load = 1'b1; tmr_val = dur(C_IDLE);
          end else if (accept) begin
            addr_d  = req_addr;
            data_d  = req_wdata;
            rdata_d = '0;
            pend_d  = 1'b0;
            rmw_d   = req_rmw && (req_op == OP_PROG);
            act_d   = (req_rmw && (req_op == OP_PROG)) ? OP_READ : nvm_op_e'(req_op);
            state_d = ST_CES; tmr_load = 1'b1; tmr_val = dur(C_CES);
          end
        end
        ST_SLEEP: if (tmr_done && !sleep_req) begin
          state_d = ST_WAKE; tmr_load = 1'b1; tmr_val = dur(C_WAKE);
        end
        ST_CES: if (tmr_done) begin
          tmr_load = 1'b1;
          if (act_q == OP_READ) begin state_d = ST_RATD; tmr_val = dur(C_ATD); end
          else                  begin state_d = ST_WSET; tmr_val = dur(C_VS);  end
        end
        ST_RATD: if (tmr_done) begin
          state_d = ST_RATO; tmr_load = 1'b1; tmr_val = dur(C_ATO);
        end
        ST_RATO: if (tmr_done) begin
          rdata_d = m_dout;
          state_d = ST_CEH; tmr_load = 1'b1; tmr_val = dur(C_CEHW);
        end
        ST_WSET: if (tmr_done) begin
          state_d = ST_WPULSE; tmr_load = 1'b1; tmr_val = dur(C_PULSE);
        end
        ST_WPULSE: if (tmr_done) begin
          state_d = ST_WHOLD; tmr_load = 1'b1; tmr_val = dur(C_WH);
        end
        ST_WHOLD: if (tmr_done) begin
          state_d = ST_CEH; tmr_load = 1'b1; tmr_val = dur(C_CEHW);
        end
        ST_CEH: if (tmr_done) begin
          if ((act_q == OP_READ) && rmw_q) begin
            rmw_d   = 1'b0;
            act_d   = need_erase ? OP_ERASE : OP_PROG;
            pend_d  = need_erase;
            state_d = ST_CES; tmr_load = 1'b1; tmr_val = dur(C_CES);
          end else if ((act_q == OP_ERASE) && pend_q) begin
            pend_d  = 1'b0;
            act_d   = OP_PROG;
            state_d = ST_CES; tmr_load = 1'b1; tmr_val = dur(C_CES);
          end else begin
            fin_d   = 1'b1;
            state_d = ST_READY;
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      act_q   <= OP_READ;
      rmw_q   <= 1'b0;
      pend_q  <= 1'b0;
      fin_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      act_q   <= act_d;
      rmw_q   <= rmw_d;
      pend_q  <= pend_d;
      fin_q   <= fin_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      rdata_q <= rdata_d;
    end
  end

  assign wr_phase  = (state_q == ST_WSET) || (state_q == ST_WPULSE) || (state_q == ST_WHOLD);
  assign m_rst_n   = (state_q != ST_OFF);
  assign m_idle_n  = (state_q != ST_OFF) && (state_q != ST_SLEEP);
  assign m_ce_n    = !(wr_phase || (state_q == ST_CES) || (state_q == ST_RATD) || (state_q == ST_RATO));
  assign m_we_n    = (state_q != ST_WPULSE);
  assign m_pgm_n   = !(wr_phase && (act_q == OP_PROG));
  assign m_ers_n   = !(wr_phase && (act_q == OP_ERASE));
  assign m_clk     = (state_q == ST_RATD);
  assign m_addr    = addr_q;
  assign m_din     = data_q;
  assign rsp_valid = fin_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned     ADDR_W       = 8,
  parameter int unsigned     DATA_W       = 8,
  parameter int unsigned     T_RST_LOW_NS = 20,
  parameter int unsigned     T_BOOT_NS    = 100_000,
  parameter int unsigned     T_RST_REC_NS = 10_000,
  parameter int unsigned     T_IDLE_MIN_NS = 5_000,
  parameter int unsigned     T_WAKE_NS    = 100_000,
  parameter int unsigned     T_CE_SETUP_NS = 10_000,
  parameter int unsigned     T_ATD_NS     = 100,
  parameter int unsigned     T_ATO_NS     = 20,
  parameter int unsigned     T_EN_SETUP_NS = 100,
  parameter int unsigned     T_PULSE_NS   = 10_000_000,
  parameter int unsigned     T_WR_HOLD_NS = 10_000,
  parameter int unsigned     T_CE_HIGH_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              sleep_req,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_rmw,
  output logic              req_err,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              m_rst_n,
  output logic              m_idle_n,
  output logic              m_ce_n,
  output logic              m_we_n,
  output logic              m_pgm_n,
  output logic              m_ers_n,
  output logic              m_clk,
  output logic [4:0]        m_mode,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_din,
  input  logic [DATA_W-1:0] m_dout
);

  localparam int unsigned C_RSTL  = ns_to_cyc(T_RST_LOW_NS, CLK_HZ);
  localparam int unsigned C_BOOT  = max2(ns_to_cyc(T_BOOT_NS, CLK_HZ), ns_to_cyc(T_RST_REC_NS, CLK_HZ));
  localparam int unsigned C_IDLE  = ns_to_cyc(T_IDLE_MIN_NS, CLK_HZ);
  localparam int unsigned C_WAKE  = ns_to_cyc(T_WAKE_NS, CLK_HZ);
  localparam int unsigned C_CES   = ns_to_cyc(T_CE_SETUP_NS, CLK_HZ);
  localparam int unsigned C_ATD   = ns_to_cyc(T_ATD_NS, CLK_HZ);
  localparam int unsigned C_ATO   = ns_to_cyc(T_ATO_NS, CLK_HZ);
  localparam int unsigned C_VS    = ns_to_cyc(T_EN_SETUP_NS, CLK_HZ);
  localparam int unsigned C_PULSE = ns_to_cyc(T_PULSE_NS, CLK_HZ);
  localparam int unsigned C_WH    = ns_to_cyc(T_WR_HOLD_NS, CLK_HZ);
  localparam int unsigned C_CEHW  = ns_to_cyc(T_CE_HIGH_NS, CLK_HZ);
  localparam int unsigned C_MAX   = max2(max2(max2(C_PULSE, C_BOOT), max2(C_WAKE, C_CES)),
                                         max2(max2(C_IDLE, C_WH), max2(C_ATD, C_RSTL)));
  localparam int unsigned CNT_W   = $clog2(C_MAX + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  nvm_delay_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_int_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  nvm_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .C_RSTL(C_RSTL), .C_BOOT(C_BOOT), .C_IDLE(C_IDLE), .C_WAKE(C_WAKE),
    .C_CES(C_CES), .C_ATD(C_ATD), .C_ATO(C_ATO), .C_VS(C_VS),
    .C_PULSE(C_PULSE), .C_WH(C_WH), .C_CEHW(C_CEHW)
  ) fsm_i (
    .clk(clk), .rst_n(rst_int_n), .supply_ok(supply_ok), .sleep_req(sleep_req),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_rmw(req_rmw),
    .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .m_rst_n(m_rst_n), .m_idle_n(m_idle_n), .m_ce_n(m_ce_n), .m_we_n(m_we_n),
    .m_pgm_n(m_pgm_n), .m_ers_n(m_ers_n), .m_clk(m_clk),
    .m_addr(m_addr), .m_din(m_din), .m_dout(m_dout)
  );

  assign req_err = req_valid && (!req_ready || (req_op == 2'b11));
  assign m_mode  = 5'h00;

endmodule

// File: rtl/nvm_seq_chk.sv
module nvm_seq_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              supply_ok,
  input logic              sleep_req,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              req_rmw,
  input logic              req_err,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              m_rst_n,
  input logic              m_idle_n,
  input logic              m_ce_n,
  input logic              m_we_n,
  input logic              m_pgm_n,
  input logic              m_ers_n,
  input logic              m_clk,
  input logic [4:0]        m_mode,
  input logic [ADDR_W-1:0] m_addr,
  input logic [DATA_W-1:0] m_din,
  input logic [DATA_W-1:0] m_dout
);

  a_r1_off_holds_macro: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!m_rst_n && !m_idle_n && !req_ready));

  a_r2_one_enable_under_we: assert property (@(posedge clk) disable iff (!rst_n)
    !m_we_n |-> (!m_ce_n && (m_pgm_n != m_ers_n)));

  a_r2_enable_before_we: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(m_we_n) |-> $past(!m_pgm_n || !m_ers_n));

  a_r5_addr_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_ce_n && $past(!m_ce_n)) |-> ($stable(m_addr) && $stable(m_din)));

  a_r10_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    !m_ce_n |-> !req_ready);

  a_r10_refused_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_err) |=> $stable(m_addr));

  a_r12_idle_ce_high: assert property (@(posedge clk) disable iff (!rst_n)
    !m_idle_n |-> (m_ce_n && m_we_n && m_pgm_n && m_ers_n));

  a_r7_rsp_after_ce_high: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> m_ce_n);

  a_r13_mode_user: assert property (@(posedge clk) disable iff (!rst_n)
    m_mode == 5'h00);

endmodule

bind nvm_seq nvm_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/nvm_seq_tb_top.sv
`timescale 1ns/1ps
module nvm_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CYC_PULSE = 200, CYC_WH = 30, CYC_CES = 20, CYC_SR = 100;
  localparam int CYC_WAKE = 50, CYC_IDLE = 10, CYC_VS = 10, CYC_ATD = 10, CYC_CEHW = 2;
  localparam int WATCHDOG = 150_000;

  logic clk = 1'b0;
  logic rst_n, supply_ok, sleep_req, req_valid, req_rmw;
  logic [1:0] req_op;
  logic [7:0] req_addr, req_wdata;
  logic req_ready, req_err, rsp_valid;
  logic [7:0] rsp_rdata;
  logic m_rst_n, m_idle_n, m_ce_n, m_we_n, m_pgm_n, m_ers_n, m_clk;
  logic [4:0] m_mode;
  logic [7:0] m_addr, m_din, m_dout;

  int checks = 0, errors = 0;
  int n_prog = 0, n_erase = 0;
  logic [7:0] mem [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_seq #(
    .CLK_HZ(100_000_000), .ADDR_W(8), .DATA_W(8),
    .T_RST_LOW_NS(20), .T_BOOT_NS(1000), .T_RST_REC_NS(200),
    .T_IDLE_MIN_NS(100), .T_WAKE_NS(500), .T_CE_SETUP_NS(200),
    .T_ATD_NS(100), .T_ATO_NS(20), .T_EN_SETUP_NS(100),
    .T_PULSE_NS(2000), .T_WR_HOLD_NS(300), .T_CE_HIGH_NS(20)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sleep_req(sleep_req),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rmw(req_rmw),
    .req_err(req_err), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .m_rst_n(m_rst_n), .m_idle_n(m_idle_n), .m_ce_n(m_ce_n), .m_we_n(m_we_n),
    .m_pgm_n(m_pgm_n), .m_ers_n(m_ers_n), .m_clk(m_clk), .m_mode(m_mode),
    .m_addr(m_addr), .m_din(m_din), .m_dout(m_dout)
  );

  // Behavioural macro: unlatched address, data valid only with chip enabled.
  assign m_dout = m_ce_n ? 8'h5A : mem[m_addr];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Pin monitor: measures every window in cycles and applies writes.
  int ce_lo = 0, ce_hi = 0, we_lo = 0, en_lo = 0, since_we = 0, clk_hi = 0;
  logic p_ce = 1, p_we = 1, p_pgm = 1, p_ers = 1, p_clk = 0;
  logic [7:0] p_addr = 0, p_din = 0;
  bit moved = 0, mon_en = 0;

  always @(negedge clk) if (mon_en) begin
    if (p_ce && !m_ce_n) chk(ce_hi >= CYC_CEHW, "R6 ce high gap", ce_hi, CYC_CEHW);
    if (!p_ce && m_ce_n) chk(!moved, "R5 addr/data stable", moved, 0);
    if (!p_ce && !m_ce_n && (m_addr != p_addr || m_din != p_din)) moved = 1;
    if (p_we && !m_we_n) begin
      chk(ce_lo >= CYC_CES, "R4 ce setup before we", ce_lo, CYC_CES);
      chk(en_lo >= CYC_VS, m_pgm_n ? "R3 enable setup" : "R2 enable setup", en_lo, CYC_VS);
      chk(m_mode == 5'h00, "R13 mode", m_mode, 0);
    end
    if (!p_we && m_we_n) begin
      chk(we_lo >= CYC_PULSE, !p_pgm ? "R2 pulse width" : "R3 pulse width", we_lo, CYC_PULSE);
      if (!p_pgm) begin mem[p_addr] = mem[p_addr] & p_din; n_prog++; end
      if (!p_ers) begin mem[p_addr] = 8'hFF; n_erase++; end
    end
    if ((!p_pgm && m_pgm_n) || (!p_ers && m_ers_n))
      chk(since_we >= CYC_WH, !p_pgm ? "R2 enable hold" : "R3 enable hold", since_we, CYC_WH);
    if (!p_clk && m_clk) chk(ce_lo >= CYC_CES, "R4 ce setup before read", ce_lo, CYC_CES);
    if (p_clk && !m_clk) chk(clk_hi >= CYC_ATD, "R7 sense width", clk_hi, CYC_ATD);
    ce_lo    = m_ce_n ? 0 : ce_lo + 1;
    ce_hi    = m_ce_n ? ce_hi + 1 : 0;
    if (m_ce_n) moved = 0;
    we_lo    = m_we_n ? 0 : we_lo + 1;
    en_lo    = (m_we_n && (!m_pgm_n || !m_ers_n) && since_we == 0) ? en_lo + 1 : (m_we_n ? 0 : en_lo);
    since_we = (m_we_n && (!m_pgm_n || !m_ers_n) && !p_we) ? 1 :
               ((since_we > 0 && (!m_pgm_n || !m_ers_n)) ? since_we + 1 : 0);
    clk_hi   = m_clk ? clk_hi + 1 : 0;
    p_ce = m_ce_n; p_we = m_we_n; p_pgm = m_pgm_n; p_ers = m_ers_n; p_clk = m_clk;
    p_addr = m_addr; p_din = m_din;
  end

  task automatic send(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d, input bit rmw);
    int n = 0;
    while (!req_ready && n < 5000) begin @(negedge clk); n++; end
    req_op = op; req_addr = a; req_wdata = d; req_rmw = rmw; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input string tag, output logic [7:0] rd);
    int n = 0;
    while (!rsp_valid && n < 5000) begin @(negedge clk); n++; end
    chk(rsp_valid, tag, rsp_valid, 1);
    rd = rsp_rdata;
    @(negedge clk);
  endtask

  task automatic do_op(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                       input bit rmw, input string tag, output logic [7:0] rd);
    send(op, a, d, rmw);
    wait_rsp(tag, rd);
  endtask

  task automatic count_to_ready(output int n);
    n = 0;
    while (!req_ready && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int n, p0, e0;
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    rst_n = 0; supply_ok = 0; sleep_req = 0; req_valid = 0; req_rmw = 0;
    req_op = 0; req_addr = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    mon_en = 1;
    chk(!m_rst_n && !m_idle_n && !req_ready, "R1 held while supply low", {m_rst_n, m_idle_n, req_ready}, 0);
    req_valid = 1; req_op = 2'b00; #1;
    chk(req_err, "R11 refused during start-up", req_err, 1);
    @(negedge clk); req_valid = 0;
    supply_ok = 1;
    count_to_ready(n);
    chk(n >= CYC_SR, "R1 start-up wait", n, CYC_SR);

    do_op(2'b00, 8'h10, 0, 0, "R7 read done", rd);
    chk(rd == 8'hFF, "R7 read blank", rd, 8'hFF);
    do_op(2'b01, 8'h10, 8'hA5, 0, "R2 program done", rd);
    chk(rd == 8'h00, "R7 rdata zero on program", rd, 0);
    do_op(2'b00, 8'h10, 0, 0, "R7 read done", rd);
    chk(rd == 8'hA5, "R2 program result", rd, 8'hA5);
    do_op(2'b01, 8'h10, 8'h5A, 0, "R8 program done", rd);
    do_op(2'b00, 8'h10, 0, 0, "R8 read done", rd);
    chk(rd == (8'hA5 & 8'h5A), "R8 program only clears", rd, 8'hA5 & 8'h5A);
    do_op(2'b10, 8'h10, 0, 0, "R3 erase done", rd);
    do_op(2'b00, 8'h10, 0, 0, "R3 read done", rd);
    chk(rd == 8'hFF, "R3 erase result", rd, 8'hFF);

    do_op(2'b01, 8'h20, 8'h3C, 0, "R9 setup", rd);
    e0 = n_erase; p0 = n_prog;
    do_op(2'b01, 8'h20, 8'h0C, 1, "R9 rmw clear-only", rd);
    chk(rd == 8'h3C, "R9 rmw returns old byte", rd, 8'h3C);
    chk(n_erase == e0 && n_prog == p0 + 1, "R9 no erase when not needed", n_erase - e0, 0);
    e0 = n_erase;
    do_op(2'b01, 8'h20, 8'hF0, 1, "R9 rmw set bits", rd);
    chk(rd == 8'h0C, "R9 rmw returns old byte", rd, 8'h0C);
    chk(n_erase == e0 + 1, "R9 erase inserted", n_erase - e0, 1);
    do_op(2'b00, 8'h20, 0, 0, "R9 read done", rd);
    chk(rd == 8'hF0, "R9 rmw result", rd, 8'hF0);

    p0 = n_prog; e0 = n_erase;
    send(2'b01, 8'h30, 8'h77, 0);
    repeat (30) @(negedge clk);
    req_valid = 1; req_op = 2'b10; req_addr = 8'h20; #1;
    chk(req_err && !req_ready, "R10 refused while busy", req_err, 1);
    @(negedge clk); req_valid = 0;
    wait_rsp("R10 program done", rd);
    repeat (3) @(negedge clk);
    chk(n_prog == p0 + 1 && n_erase == e0, "R10 refused request no effect", n_erase - e0, 0);
    do_op(2'b00, 8'h20, 0, 0, "R10 read done", rd);
    chk(rd == 8'hF0, "R10 other byte untouched", rd, 8'hF0);

    req_valid = 1; req_op = 2'b11; #1;
    chk(req_err, "R11 invalid op refused", req_err, 1);
    @(negedge clk); req_valid = 0;
    repeat (2) @(negedge clk);
    chk(req_ready && m_ce_n, "R11 invalid op not executed", m_ce_n, 1);

    sleep_req = 1;
    @(negedge clk);
    chk(!m_idle_n && m_ce_n, "R12 idle entered", m_idle_n, 0);
    req_valid = 1; req_op = 2'b00; #1;
    chk(req_err, "R11 refused during idle", req_err, 1);
    @(negedge clk); req_valid = 0;
    sleep_req = 0;
    n = 2;
    while (!m_idle_n && n < 5000) begin @(negedge clk); n++; end
    chk(n >= CYC_IDLE, "R12 idle minimum", n, CYC_IDLE);
    count_to_ready(n);
    chk(n >= CYC_WAKE, "R12 wake wait", n, CYC_WAKE);

    supply_ok = 0;
    @(negedge clk);
    chk(!m_rst_n && !m_idle_n && !req_ready, "R1 supply drop holds macro", {m_rst_n, m_idle_n}, 0);
    repeat (5) @(negedge clk);
    supply_ok = 1;
    count_to_ready(n);
    chk(n >= CYC_SR, "R1 restart wait", n, CYC_SR);
    do_op(2'b00, 8'h30, 0, 0, "R7 read done", rd);
    chk(rd == 8'h77, "R7 read after restart", rd, 8'h77);

    summary();
    $finish;
  end

endmodule